// File: doc/BRIEF.md
# Condition Flag Register Unit

This block holds a 32-bit condition register built from eight 4-bit flag fields. Every field uses the same bit layout: bit 0 is less-than (negative), bit 1 is greater-than (positive), bit 2 is equal (zero) and bit 3 is summary overflow. Two fields have fixed roles. Field 0 takes flags derived from a signed fixed-point result, with the overflow bit mirrored from the sticky overflow flag of the fixed-point exception register. Field 1 is loaded with the four low status bits of the floating-point status register. A compare writes its flags into any field it names.

Single-bit logic combines any two register bits with one of eight Boolean functions and writes the result into any register bit. A combinational test port picks one bit of one field for branch evaluation. The whole register is also visible on an output. All updates are registered and appear on the cycle after the edge that takes them.

Top module: `cond_reg_unit`

## Requirements
- R1: After reset every one of the 32 register bits is 0.
- R2: With `res_valid` high, field 0 (register bits 3:0) takes flags from `res_value` read as signed: negative gives bits 2:0 = 001, positive gives 010, zero gives 100, so exactly one relation bit is set.
- R3: With `res_valid` high, register bit 3 takes the value of `ovf_sticky`.
- R4: With `fpst_valid` high, field 1 (register bits 7:4) takes `fpst_low`, its bit 0 into register bit 4.
- R5: With `cmp_valid` high, the field numbered `cmp_field` (register bits 4*f+3 down to 4*f) takes {so, eq, gt, lt} from a signed compare of `cmp_a` against `cmp_b` with so = `cmp_so`; exactly one relation bit is set. A compare aimed at field 0 or 1 wins over the fixed-role update of that field in the same cycle.
- R6: `logic_op` selects the bit function of source a and source b: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 equivalence (XNOR), 6 a AND NOT b, 7 a OR NOT b.
- R7: With `logic_valid` high, register bit `logic_dst` takes the function of register bits `logic_src_a` and `logic_src_b` as they stood before the edge; the bit-logic write wins over any field update to the same bit, while the other bits of that field still take the field update.
- R8: `test_out` equals register bit 4*`test_field` + `test_pos`, combinationally.
- R9: In a cycle with no valid input the register keeps its value.
- R10: Each update is visible on `reg_out` and `test_out` one clock edge after the inputs that request it, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Update field 0 from a fixed-point result |
| res_value | input | 32 | Fixed-point result, signed |
| ovf_sticky | input | 1 | Sticky overflow from the exception register |
| fpst_valid | input | 1 | Load field 1 from the floating-point status |
| fpst_low | input | 4 | Low four floating-point status bits |
| cmp_valid | input | 1 | Write a compare result into a field |
| cmp_field | input | 3 | Destination field of the compare |
| cmp_a | input | 32 | Compare left operand, signed |
| cmp_b | input | 32 | Compare right operand, signed |
| cmp_so | input | 1 | Summary overflow written with the compare |
| logic_valid | input | 1 | Perform a single-bit logic operation |
| logic_op | input | 3 | Bit function code |
| logic_src_a | input | 5 | Register bit index of source a |
| logic_src_b | input | 5 | Register bit index of source b |
| logic_dst | input | 5 | Register bit index of the destination |
| test_field | input | 3 | Field picked for the branch test |
| test_pos | input | 2 | Bit within the picked field |
| test_out | output | 1 | Value of the picked bit |
| reg_out | output | 32 | Whole register contents |

## Verification
Every write (field 0, field 1, compare and bit logic) is due exactly one rising edge after the cycle its valid is high, while the branch test is due in the same cycle its select changes. The bench drives inputs at the falling edge, lets one rising edge pass, and compares the register against a bench model at the next falling edge; the test port is read a short delay after its select changes with no edge in between. Idle cycles are checked the same way to show that nothing moves without a valid.

// File: rtl/cru_pkg.sv
package cru_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_NAND = 3'd3,
        OP_NOR  = 3'd4,
        OP_EQV  = 3'd5,
        OP_ANDC = 3'd6,
        OP_ORC  = 3'd7
    } bitop_e;

    // Bit 0 of a field is less-than, bit 3 is summary overflow.
    typedef struct packed {
        logic so;
        logic eq;
        logic gt;
        logic lt;
    } flags_t;

endpackage

// File: rtl/cru_relation.sv
module cru_relation #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              so_in,
    output cru_pkg::flags_t   flags
);
    always_comb begin
        flags.lt = $signed(lhs) < $signed(rhs);
        flags.gt = $signed(lhs) > $signed(rhs);
        flags.eq = (lhs == rhs);
        flags.so = so_in;
    end
endmodule

// File: rtl/cru_bit_op.sv
module cru_bit_op (
    input  logic [2:0] op,
    input  logic       a,
    input  logic       b,
    output logic       y
);
    import cru_pkg::*;

    always_comb begin
        case (bitop_e'(op))
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NAND: y = ~(a & b);
            OP_NOR:  y = ~(a | b);
            OP_EQV:  y = ~(a ^ b);
            OP_ANDC: y = a & ~b;
            OP_ORC:  y = a | ~b;
            default: y = 1'b0;
        endcase
    end
endmodule

// File: rtl/cru_bit_pick.sv
module cru_bit_pick #(
    parameter int VEC_W = 32,
    parameter int IDX_W = 5
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    always_comb begin
        bit_o = 1'b0;
        if (int'(idx) < VEC_W) bit_o = vec[idx];
    end
endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit #(
    parameter  int NUM_FIELDS = 8,
    parameter  int DATA_W     = 32,
    localparam int FW         = cru_pkg::FLAG_W,
    localparam int REG_W      = NUM_FIELDS * FW,
    localparam int SEL_W      = $clog2(NUM_FIELDS),
    localparam int POS_W      = $clog2(FW),
    localparam int BIT_W      = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_value,
    input  logic              ovf_sticky,
    input  logic              fpst_valid,
    input  logic [FW-1:0]     fpst_low,
    input  logic              cmp_valid,
    input  logic [SEL_W-1:0]  cmp_field,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              cmp_so,
    input  logic              logic_valid,
    input  logic [2:0]        logic_op,
    input  logic [BIT_W-1:0]  logic_src_a,
    input  logic [BIT_W-1:0]  logic_src_b,
    input  logic [BIT_W-1:0]  logic_dst,
    input  logic [SEL_W-1:0]  test_field,
    input  logic [POS_W-1:0]  test_pos,
    output logic              test_out,
    output logic [REG_W-1:0]  reg_out
);
    import cru_pkg::*;

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    flags_t res_flags;
    flags_t cmp_flags;
    logic   src_a_bit, src_b_bit, logic_y;

    // Field 0 source: result measured against zero.
    cru_relation #(.DATA_W(DATA_W)) u_res_rel (
        .lhs   (res_value),
        .rhs   ('0),
        .so_in (ovf_sticky),
        .flags (res_flags)
    );

    cru_relation #(.DATA_W(DATA_W)) u_cmp_rel (
        .lhs   (cmp_a),
        .rhs   (cmp_b),
        .so_in (cmp_so),
        .flags (cmp_flags)
    );

    cru_bit_pick #(.VEC_W(REG_W), .IDX_W(BIT_W)) u_pick_a (
        .vec (st_q.bits), .idx (logic_src_a), .bit_o (src_a_bit)
    );

    cru_bit_pick #(.VEC_W(REG_W), .IDX_W(BIT_W)) u_pick_b (
        .vec (st_q.bits), .idx (logic_src_b), .bit_o (src_b_bit)
    );

    cru_bit_pick #(.VEC_W(REG_W), .IDX_W(BIT_W)) u_pick_test (
        .vec (st_q.bits), .idx ({test_field, test_pos}), .bit_o (test_out)
    );

    cru_bit_op u_bit_op (
        .op (logic_op), .a (src_a_bit), .b (src_b_bit), .y (logic_y)
    );

    // Priority, lowest first: fixed-role fields, compare, bit logic.
    always_comb begin
        st_d = st_q;
        if (res_valid)
            st_d.bits[0 +: FW] = res_flags;
        if (fpst_valid)
            st_d.bits[FW +: FW] = fpst_low;
        if (cmp_valid && (int'(cmp_field) < NUM_FIELDS))
            st_d.bits[cmp_field*FW +: FW] = cmp_flags;
        if (logic_valid && (int'(logic_dst) < REG_W))
            st_d.bits[logic_dst] = logic_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_out = st_q.bits;

    // ---------------- assertions ----------------
    logic f0_cmp_hit, f1_cmp_hit, f0_lg_hit, f1_lg_hit, cmp_lg_hit, any_valid;
    assign f0_cmp_hit = cmp_valid && (cmp_field == SEL_W'(0));
    assign f1_cmp_hit = cmp_valid && (cmp_field == SEL_W'(1));
    assign f0_lg_hit  = logic_valid && (logic_dst[BIT_W-1:POS_W] == SEL_W'(0));
    assign f1_lg_hit  = logic_valid && (logic_dst[BIT_W-1:POS_W] == SEL_W'(1));
    assign cmp_lg_hit = logic_valid && (logic_dst[BIT_W-1:POS_W] == cmp_field);
    assign any_valid  = res_valid | fpst_valid | cmp_valid | logic_valid;

    p_field0_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !f0_cmp_hit && !f0_lg_hit |=> $countones(reg_out[2:0]) == 1);

    p_so_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !f0_cmp_hit && !f0_lg_hit |=> reg_out[3] == $past(ovf_sticky));

    p_fp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fpst_valid && !f1_cmp_hit && !f1_lg_hit |=> reg_out[FW +: FW] == $past(fpst_low));

    p_cmp_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && !cmp_lg_hit |=> $countones(reg_out[$past(cmp_field)*FW +: 3]) == 1);

    p_bitlogic_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        logic_valid |=> reg_out[$past(logic_dst)] == $past(logic_y));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_valid |=> $stable(reg_out));

endmodule

// File: tb/cond_reg_unit_test.sv
module cond_reg_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 0;
    logic [31:0] res_value = '0;
    logic        ovf_sticky = 0;
    logic        fpst_valid = 0;
    logic [3:0]  fpst_low = '0;
    logic        cmp_valid = 0;
    logic [2:0]  cmp_field = '0;
    logic [31:0] cmp_a = '0, cmp_b = '0;
    logic        cmp_so = 0;
    logic        logic_valid = 0;
    logic [2:0]  logic_op = '0;
    logic [4:0]  logic_src_a = '0, logic_src_b = '0, logic_dst = '0;
    logic [2:0]  test_field = '0;
    logic [1:0]  test_pos = '0;
    logic        test_out;
    logic [31:0] reg_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_reg_unit uut (
        .clk, .rst_n, .res_valid, .res_value, .ovf_sticky,
        .fpst_valid, .fpst_low, .cmp_valid, .cmp_field, .cmp_a, .cmp_b, .cmp_so,
        .logic_valid, .logic_op, .logic_src_a, .logic_src_b, .logic_dst,
        .test_field, .test_pos, .test_out, .reg_out
    );

    function automatic logic ref_op(input logic [2:0] op, input logic a, input logic b);
        case (op)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return !(a & b);
            3'd4: return !(a | b);
            3'd5: return a == b;
            3'd6: return a & !b;
            default: return a | !b;
        endcase
    endfunction

    function automatic logic [3:0] rel(input logic [31:0] x, input logic [31:0] y, input logic so);
        logic signed [31:0] sx, sy;
        sx = x; sy = y;
        if (sx < sy)      return {so, 3'b001};
        else if (sx > sy) return {so, 3'b010};
        else              return {so, 3'b100};
    endfunction

    function automatic logic [31:0] ref_next();
        logic [31:0] m;
        m = model;
        if (res_valid)   m[3:0] = rel(res_value, 32'd0, ovf_sticky);
        if (fpst_valid)  m[7:4] = fpst_low;
        if (cmp_valid)   m[cmp_field*4 +: 4] = rel(cmp_a, cmp_b, cmp_so);
        if (logic_valid) m[logic_dst] = ref_op(logic_op, model[logic_src_a], model[logic_src_b]);
        return m;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge with inputs set; one rising edge then passes.
    task automatic tick(input string req);
        logic [31:0] exp;
        exp = ref_next();
        @(posedge clk);
        #1;
        // R10: nothing may change before the edge that takes the inputs
        @(negedge clk);
        res_valid = 0; fpst_valid = 0; cmp_valid = 0; logic_valid = 0;
        check32(req, reg_out, exp);
        model = exp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] vals [6];
        vals = '{32'd0, 32'd7, 32'hFFFF_FFFB, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1};

        repeat (3) @(negedge clk);
        rst_n = 1;
        check32("R1 reset", reg_out, 32'd0);

        // R10: a valid must not show before its edge
        res_valid = 1; res_value = 32'hFFFF_FFFF; ovf_sticky = 1;
        #1 check32("R10 no early update", reg_out, 32'd0);
        tick("R2 R3 negative with overflow");

        // R2/R3 sweep of result values
        foreach (vals[i]) begin
            res_valid = 1; res_value = vals[i]; ovf_sticky = i[0];
            tick("R2 R3 result sweep");
        end

        // R4 every status pattern
        for (int v = 0; v < 16; v++) begin
            fpst_valid = 1; fpst_low = 4'(v);
            tick("R4 status load");
        end

        // R5 every field, three relations
        for (int f = 0; f < 8; f++) begin
            for (int r = 0; r < 3; r++) begin
                cmp_valid = 1; cmp_field = 3'(f); cmp_so = r[0];
                cmp_a = (r == 0) ? 32'hFFFF_FFF0 : 32'd5;
                cmp_b = (r == 1) ? 32'hFFFF_FFF0 : 32'd5;
                tick("R5 compare sweep");
            end
        end

        // R5 compare beats fixed-role updates
        res_valid = 1; res_value = 32'd9; ovf_sticky = 0;
        cmp_valid = 1; cmp_field = 0; cmp_a = 1; cmp_b = 2; cmp_so = 1;
        tick("R5 compare over result on field 0");
        fpst_valid = 1; fpst_low = 4'hF;
        cmp_valid = 1; cmp_field = 1; cmp_a = 3; cmp_b = 3; cmp_so = 0;
        tick("R5 compare over status on field 1");

        // R6 all functions, all operand pairs; bits 4..7 = 1,0,1,0
        fpst_valid = 1; fpst_low = 4'b0101;
        tick("R4 setup");
        for (int op = 0; op < 8; op++) begin
            for (int ab = 0; ab < 4; ab++) begin
                logic_valid = 1; logic_op = 3'(op);
                logic_src_a = ab[1] ? 5'd4 : 5'd5;
                logic_src_b = ab[0] ? 5'd6 : 5'd7;
                logic_dst = 5'(8 + ((op * 4 + ab) % 24));
                tick("R6 bit function sweep");
            end
        end

        // R7 bit logic beats result update on the same bit, rest of field updates
        res_valid = 1; res_value = 32'd3; ovf_sticky = 1;
        logic_valid = 1; logic_op = 3'd0; logic_src_a = 5'd5; logic_src_b = 5'd5; logic_dst = 5'd1;
        tick("R7 bit logic over field 0 update");
        // R7 source read before edge: destination is also a source
        logic_valid = 1; logic_op = 3'd4; logic_src_a = 5'd1; logic_src_b = 5'd1; logic_dst = 5'd1;
        tick("R7 old value read");
        cmp_valid = 1; cmp_field = 5; cmp_a = 0; cmp_b = 0; cmp_so = 0;
        logic_valid = 1; logic_op = 3'd1; logic_src_a = 5'd4; logic_src_b = 5'd5; logic_dst = 5'd23;
        tick("R7 bit logic over compare");

        // R9 idle hold
        for (int k = 0; k < 4; k++) tick("R9 idle hold");

        // R8 test port over every bit, two patterns
        for (int pass = 0; pass < 2; pass++) begin
            cmp_valid = 1; cmp_field = 3'(2 + pass); cmp_a = 1; cmp_b = 0; cmp_so = 1;
            tick("R5 setup");
            for (int f = 0; f < 8; f++) begin
                for (int b = 0; b < 4; b++) begin
                    test_field = 3'(f); test_pos = 2'(b);
                    #1 check32("R8 test port", {31'd0, test_out}, {31'd0, model[f*4+b]});
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule